// File: doc/BRIEF.md
# Periodic Scan Trigger Timer

This block produces the timed start requests for a queue of analog conversions. A free-running counter advances once per prescaled clock strobe. When it reaches the terminal count picked by a 4-bit interval select, the block emits a single-cycle trigger and the counter starts again from zero. The interval is 2^(7+sel) strobes, so it runs from 128 to 4,194,304 strobes.

Two mechanisms clear the counter. A held clear keeps it at zero while any gating condition is true:

- the queue mode does not use the timer;
- single-scan mode is selected but its enable is not armed;
- master reset, stop or an enabled freeze is active.

A pulsed clear zeroes it once, either on wrap at the terminal count or when software switches directly between the two timer modes. Entering stop wipes the mode register, so the timer stays idle after stop until software writes a timer mode again. In single-scan mode the enable disarms itself when its trigger is issued, which gives exactly one trigger per arming.

Top module: `pit_scan_timer`

## Requirements
- R1: After the asynchronous reset, the mode register holds code 0 and no trigger appears until software writes a timer mode.
- R2: In continuous timer mode (mode code 4) with sel fixed, `trig` goes high for exactly one clock once every 2^(7+sel) strobes. The first pulse follows 2^(7+sel) strobes after the counter leaves its cleared state, and it appears in the cycle after the clock edge that sampled the final strobe.
- R3: The counter advances only on clock edges where `step_stb` is high. Cycles without a strobe neither advance nor clear it.
- R4: Mode codes 0, 1, 2, 5, 6 and 7 do not use the timer. While one of them is in the mode register, the counter is held at zero and `trig` stays low.
- R5: In single-scan timer mode (mode code 3) the counter is held at zero while the single-scan enable is clear. A one-cycle `ss_set` pulse sets the enable.
- R6: In single-scan timer mode the enable clears on the edge that issues the trigger, so one arming yields exactly one trigger.
- R7: While `master_rst` is high, or `stop_req` is high, or both `freeze` and `frz_en` are high, the counter is held at zero. `freeze` with `frz_en` low has no effect.
- R8: `stop_req` clears the mode register to code 0, with priority over a mode write in the same cycle. After stop ends the timer stays idle until a timer mode is written.
- R9: A mode write that changes the mode from code 3 to code 4, or from code 4 to code 3, clears the counter once. Rewriting the current mode does not clear it.
- R10: A trigger fires on any strobe where the count is at or above the terminal count. If sel is lowered below the current count, the trigger is issued on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| master_rst | input | 1 | Synchronous master reset; holds the counter at zero |
| stop_req | input | 1 | Low-power stop request; holds the counter and clears the mode register |
| freeze | input | 1 | Debug freeze line |
| frz_en | input | 1 | Lets `freeze` hold the counter |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 3 | Mode code to write: 3 is single-scan timer, 4 is continuous timer, all others are non-timer |
| ss_set | input | 1 | Sets the single-scan enable |
| int_sel | input | 4 | Interval select; the interval is 2^(7+int_sel) strobes |
| step_stb | input | 1 | Prescaled clock strobe that advances the counter |
| trig | output | 1 | One-cycle scan trigger |

## Verification
Interval selects 0 through 5 are swept with a strobe on every clock, and selects 0 and 1 with a strobe on every third clock. Comparing the measured trigger cycle with 2^(7+sel) times the strobe period separates a wrong terminal decode from wrong strobe gating. Each held-clear source is applied partway through an interval. The trigger is then expected a full interval after release; it would arrive early if the counter were only paused instead of cleared. The same early-versus-full-interval contrast separates a genuine 3-to-4 mode switch from a rewrite of the same mode. Stop combined with a simultaneous write, and lowering sel below the running count, cover the ordering corner cases.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF        = 3'd0,
    PM_SOFT       = 3'd1,
    PM_EXT        = 3'd2,
    PM_TMR_SINGLE = 3'd3,
    PM_TMR_CONT   = 3'd4,
    PM_RSV5       = 3'd5,
    PM_RSV6       = 3'd6,
    PM_RSV7       = 3'd7
  } pit_mode_e;

  function automatic logic pit_uses_timer(input logic [MODE_W-1:0] m);
    return (m == PM_TMR_SINGLE) || (m == PM_TMR_CONT);
  endfunction

endpackage

// File: rtl/pit_mode_ctrl.sv
module pit_mode_ctrl
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_rst,
  input  logic              stop_req,
  input  logic              freeze,
  input  logic              frz_en,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              ss_set,
  input  logic              fire,
  output logic [MODE_W-1:0] mode_q,
  output logic              ss_en_q,
  output logic              hold,
  output logic              clr_pulse
);

  logic [MODE_W-1:0] mode_d;
  logic              ss_en_d;
  logic              mode_en;
  logic              ss_en_en;
  logic              single_sel;

  assign single_sel = (mode_q == PM_TMR_SINGLE);

  // Level clear sources
  always_comb begin
    hold = master_rst
         | stop_req
         | (freeze & frz_en)
         | ~pit_uses_timer(mode_q)
         | (single_sel & ~ss_en_q);
  end

  // Direct switch between the two timer modes
  always_comb begin
    clr_pulse = mode_wr & ~stop_req
              & pit_uses_timer(mode_q)
              & pit_uses_timer(mode_wdata)
              & (mode_wdata != mode_q);
  end

  // Mode register next state: stop wins over a write
  always_comb begin
    mode_en = stop_req | mode_wr;
    if (stop_req) begin
      mode_d = MODE_W'(PM_OFF);
    end else begin
      mode_d = mode_wdata;
    end
  end

  // Single-scan enable: disarm on issued trigger wins over arming
  always_comb begin
    ss_en_en = ss_set | (fire & single_sel);
    if (fire && single_sel) begin
      ss_en_d = 1'b0;
    end else begin
      ss_en_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_W'(PM_OFF);
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_en_q <= 1'b0;
    end else if (ss_en_en) begin
      ss_en_q <= ss_en_d;
    end
  end

endmodule

// File: rtl/pit_term_dec.sv
module pit_term_dec #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned BASE_EXP = 7,
  localparam int unsigned CNT_W   = BASE_EXP + (1 << SEL_W) - 1,
  localparam int unsigned EXP_W   = $clog2(CNT_W + 1)
) (
  input  logic [SEL_W-1:0] int_sel,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             at_term
);

  logic [EXP_W-1:0] exp_w;
  logic [CNT_W-1:0] term_w;

  assign exp_w = EXP_W'(BASE_EXP) + EXP_W'(int_sel);

  // Terminal count = 2^exp - 1, built bit by bit
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_term
    assign term_w[gi] = (exp_w > EXP_W'(gi));
  end

  assign at_term = (cnt_q >= term_w);

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_stb,
  input  logic             hold,
  input  logic             clr_pulse,
  input  logic             at_term,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire,
  output logic             trig
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign fire = step_stb & ~hold & ~clr_pulse & at_term;

  always_comb begin
    cnt_en = hold | clr_pulse | step_stb;
    if (hold || clr_pulse || fire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= 1'b0;
    end else begin
      trig <= fire;
    end
  end

endmodule

// File: rtl/pit_scan_timer.sv
module pit_scan_timer
  import pit_pkg::*;
#(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned BASE_EXP = 7,
  localparam int unsigned CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_rst,
  input  logic              stop_req,
  input  logic              freeze,
  input  logic              frz_en,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              ss_set,
  input  logic [SEL_W-1:0]  int_sel,
  input  logic              step_stb,
  output logic              trig
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [MODE_W-1:0] mode_q;
  logic              ss_en_q;
  logic              hold;
  logic              clr_pulse;
  logic              fire;
  logic              at_term;
  logic [CNT_W-1:0]  cnt_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  pit_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .master_rst (master_rst),
    .stop_req   (stop_req),
    .freeze     (freeze),
    .frz_en     (frz_en),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .ss_set     (ss_set),
    .fire       (fire),
    .mode_q     (mode_q),
    .ss_en_q    (ss_en_q),
    .hold       (hold),
    .clr_pulse  (clr_pulse)
  );

  pit_term_dec #(
    .SEL_W    (SEL_W),
    .BASE_EXP (BASE_EXP)
  ) u_term (
    .int_sel (int_sel),
    .cnt_q   (cnt_q),
    .at_term (at_term)
  );

  pit_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_stb  (step_stb),
    .hold      (hold),
    .clr_pulse (clr_pulse),
    .at_term   (at_term),
    .cnt_q     (cnt_q),
    .fire      (fire),
    .trig      (trig)
  );

endmodule

// File: rtl/pit_scan_timer_chk.sv
module pit_scan_timer_chk
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 22
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              stop_req,
  input logic              step_stb,
  input logic              hold,
  input logic              clr_pulse,
  input logic [MODE_W-1:0] mode_q,
  input logic              ss_en_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              trig
);

  AST_HOLD_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold |=> (cnt_q == '0)); // R7

  AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig |=> !trig); // R2

  AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_stb && !hold && !clr_pulse) |=> $stable(cnt_q)); // R3

  AST_STOP_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_req |=> (mode_q == MODE_W'(PM_OFF))); // R8

  AST_NONTIMER_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pit_uses_timer($past(mode_q)) |-> !trig); // R4

  AST_SINGLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trig && mode_q == MODE_W'(PM_TMR_SINGLE) && $past(mode_q) == MODE_W'(PM_TMR_SINGLE))
      |-> !ss_en_q); // R6

  AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_pulse |=> (cnt_q == '0)); // R9

endmodule

bind pit_scan_timer pit_scan_timer_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .stop_req   (stop_req),
  .step_stb   (step_stb),
  .hold       (hold),
  .clr_pulse  (clr_pulse),
  .mode_q     (mode_q),
  .ss_en_q    (ss_en_q),
  .cnt_q      (cnt_q),
  .trig       (trig)
);

// File: tb/pit_scan_timer_tb.sv
`timescale 1ns/1ps
module pit_scan_timer_tb;

  logic       clk;
  logic       rst_n;
  logic       master_rst;
  logic       stop_req;
  logic       freeze;
  logic       frz_en;
  logic       mode_wr;
  logic [2:0] mode_wdata;
  logic       ss_set;
  logic [3:0] int_sel;
  logic       step_stb;
  logic       trig;

  int checks;
  int errors;
  bit done;

  pit_scan_timer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_rst (master_rst),
    .stop_req   (stop_req),
    .freeze     (freeze),
    .frz_en     (frz_en),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .ss_set     (ss_set),
    .int_sel    (int_sel),
    .step_stb   (step_stb),
    .trig       (trig)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge. Edge c carries a strobe when c % period == 0.
  // Returns the edge count after which trig was first seen, or -1.
  task automatic run_until(input int period, input int maxc, output int found);
    found = -1;
    step_stb = ((1 % period) == 0);
    for (int c = 1; c <= maxc; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (trig) begin
        found = c;
        break;
      end
      step_stb = (((c + 1) % period) == 0);
    end
  endtask

  task automatic wr_mode(input logic [2:0] m);
    step_stb   = 1'b0;
    mode_wr    = 1'b1;
    mode_wdata = m;
    @(negedge clk);
    mode_wr    = 1'b0;
  endtask

  task automatic pulse_ss();
    step_stb = 1'b0;
    ss_set   = 1'b1;
    @(negedge clk);
    ss_set   = 1'b0;
  endtask

  task automatic settle();
    step_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_400_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int got;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; master_rst = 1'b0; stop_req = 1'b0; freeze = 1'b0; frz_en = 1'b0;
    mode_wr = 1'b0; mode_wdata = 3'd0; ss_set = 1'b0; int_sel = 4'd0; step_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, strobes present but no mode written
    check("R1 trig low after reset", int'(trig), 0);
    run_until(1, 300, got);
    check("R1 no trigger before a timer mode is written", got, -1);

    // R2: interval sweep with a strobe every clock, two pulses each
    for (int s = 0; s <= 5; s++) begin
      wr_mode(3'd0);
      int_sel = 4'(s);
      wr_mode(3'd4);
      run_until(1, (1 << (7 + s)) + 5, got);
      check($sformatf("R2 first interval sel=%0d", s), got, 1 << (7 + s));
      run_until(1, (1 << (7 + s)) + 5, got);
      check($sformatf("R2 second interval and one-cycle width sel=%0d", s), got, 1 << (7 + s));
    end

    // R3: strobe every third clock
    for (int s = 0; s <= 1; s++) begin
      wr_mode(3'd0);
      int_sel = 4'(s);
      wr_mode(3'd4);
      run_until(3, 3 * (1 << (7 + s)) + 5, got);
      check($sformatf("R3 interval with strobe period 3 sel=%0d", s), got, 3 * (1 << (7 + s)));
    end

    // R3: cycles without strobe neither advance nor clear
    int_sel = 4'd0;
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 60, got);
    run_until(1000, 50, got);
    check("R3 no trigger while strobe idle", got, -1);
    run_until(1, 200, got);
    check("R3 count resumes where it stopped", got, 68);

    // R4: non-timer modes hold the counter
    for (int m = 0; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      wr_mode(3'(m));
      run_until(1, 300, got);
      check($sformatf("R4 mode %0d gives no trigger", m), got, -1);
    end

    // R5: single-scan without enable holds; ss_set arms it
    wr_mode(3'd0);
    wr_mode(3'd3);
    run_until(1, 300, got);
    check("R5 single-scan unarmed gives no trigger", got, -1);
    pulse_ss();
    run_until(1, 200, got);
    check("R5 armed single-scan triggers after interval", got, 128);
    // R6: only one trigger per arming
    run_until(1, 600, got);
    check("R6 single-scan enable disarmed after trigger", got, -1);

    // R7: enabled freeze clears the counter
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 60, got);
    freeze = 1'b1; frz_en = 1'b1;
    run_until(1, 20, got);
    check("R7 no trigger during enabled freeze", got, -1);
    freeze = 1'b0;
    settle();
    run_until(1, 200, got);
    check("R7 freeze clears counter", got, 128);

    // R7: freeze with enable low has no effect
    frz_en = 1'b0;
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 60, got);
    freeze = 1'b1;
    run_until(1, 20, got);
    freeze = 1'b0;
    run_until(1, 200, got);
    check("R7 freeze without enable ignored", got, 48);

    // R7: master reset clears the counter
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 60, got);
    master_rst = 1'b1;
    run_until(1, 20, got);
    check("R7 no trigger during master reset", got, -1);
    master_rst = 1'b0;
    settle();
    run_until(1, 200, got);
    check("R7 master reset clears counter", got, 128);

    // R8: stop clears the mode; timer idle until rewritten
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 60, got);
    stop_req = 1'b1;
    run_until(1, 3, got);
    stop_req = 1'b0;
    run_until(1, 400, got);
    check("R8 timer idle after stop", got, -1);
    wr_mode(3'd4);
    run_until(1, 200, got);
    check("R8 rewritten mode restarts timer", got, 128);

    // R8: stop wins over a simultaneous write
    wr_mode(3'd0);
    step_stb = 1'b0; stop_req = 1'b1; mode_wr = 1'b1; mode_wdata = 3'd4;
    @(negedge clk);
    stop_req = 1'b0; mode_wr = 1'b0;
    run_until(1, 300, got);
    check("R8 stop overrides same-cycle write", got, -1);

    // R9: switching between timer modes clears once
    wr_mode(3'd0);
    pulse_ss();
    wr_mode(3'd4);
    run_until(1, 100, got);
    wr_mode(3'd3);
    run_until(1, 200, got);
    check("R9 switch 4 to 3 clears counter", got, 128);

    // R9: rewriting the same mode does not clear
    wr_mode(3'd0);
    wr_mode(3'd4);
    run_until(1, 100, got);
    wr_mode(3'd4);
    run_until(1, 200, got);
    check("R9 same-mode rewrite keeps count", got, 28);

    // R10: lowering sel below the running count
    wr_mode(3'd0);
    int_sel = 4'd2;
    wr_mode(3'd4);
    run_until(1, 200, got);
    int_sel = 4'd0;
    run_until(1, 5, got);
    check("R10 trigger on next strobe after sel lowered", got, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule